// File: doc/BRIEF.md
# Dual-Mode DAC Input Register

This block is the digital front end of a precision digital-to-analog converter. A data word arrives either one bit at a time or as two bytes, always accompanied by a rising edge on a chip-select strobe. The word collects in a first-rank register and moves on to a second-rank latch. The latch output is the code that the converter core receives. A mode input selects serial or byte loading. In serial mode three of the data pins change their meaning: one carries the serial bit, one sets the shift order and one sets the word length. A chain output makes the first rank usable as one stage of a daisy chain of several converters.

The second rank is modelled as a state machine with four states. `RK_TRACK` follows the first rank while the load input is high. `RK_HOLD` keeps the last code once load falls. `RK_CLR_ZERO` and `RK_CLR_MID` force the code to all zeros or to midscale while clear is high, and they keep that value after clear falls until load is raised again. The transitions are:
- clear high: to `RK_CLR_MID` if the clear-target input is high, otherwise to `RK_CLR_ZERO`, from any state;
- clear low and load high: to `RK_TRACK`;
- clear and load both low: from `RK_TRACK` to `RK_HOLD`, while `RK_HOLD` and the two clear states stay where they are.

All inputs pass through a two-stage synchroniser on the system clock, and chip-select edges are detected on that clock. The output code is always `LONG_W` (18) bits wide. A 16-bit word sits in the upper 16 bits, with the two lowest bits zero.

Top module: `dac_word_frontend`

## Requirements
- R1: After reset, `dac_code` is 0, `chain_out` is 0 and `mid_cleared` is 0.
- R2: When `byte_mode` is low, each rising edge of `cs_strobe` shifts one bit taken from `data_in[0]`. With `data_in[1]`=1 (MSB first) and `data_in[2]`=0 (16-bit), sixteen strobes carrying word W from bit 15 down to bit 0 give `dac_code` = {W[15:0], 2'b00} while load is high.
- R3: With `data_in[1]`=0 (LSB first), the bits are sent from bit 0 upward and enter at the top of the active word. The same word W then results.
- R4: With `data_in[2]`=1, the word is 18 bits long and `dac_code` = W[17:0] after eighteen strobes, in either order.
- R5: In serial mode, `hi_sel` and `lo_sel` have no effect on the loaded word.
- R6: `chain_out` shows the top bit of the active word: bit 15 of the first rank for 16-bit words and bit 17 for 18-bit words. Each further MSB-first strobe moves the next bit out, and `dac_code` shows the shifted word.
- R7: When `byte_mode` is high, a strobe writes `data_in` into the high byte if `hi_sel` is set and into the low byte if `lo_sel` is set. The other byte is untouched. The two bytes may be written in either order, and the result is `dac_code` = {hi, lo, 2'b00}.
- R8: While `load_en` is high, first-rank changes reach `dac_code` without any further strobe. While `load_en` is low, `dac_code` holds its value.
- R9: While `clear` is high, `dac_code` is 0 with `mid_cleared`=0 if `clear_to_mid` is low. If `clear_to_mid` is high, `dac_code` is 18'h20000 (MSB only) with `mid_cleared`=1. Clear takes priority over load.
- R10: Clear leaves the first rank unchanged. After clear falls, the clear value stays until `load_en` is high, and then the first-rank word reappears with `mid_cleared`=0.
- R11: Only a rising edge of `cs_strobe` writes. Data changes while the strobe is held high, and the falling edge, do not alter the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_strobe | input | 1 | Chip-select strobe; its rising edge writes |
| byte_mode | input | 1 | 1 = byte loading, 0 = serial loading |
| data_in | input | BYTE_W | Byte data; in serial mode bit 0 = serial bit, bit 1 = MSB first, bit 2 = 18-bit word |
| hi_sel | input | 1 | High-byte enable (byte mode) |
| lo_sel | input | 1 | Low-byte enable (byte mode) |
| load_en | input | 1 | Second rank follows the first rank while high |
| clear | input | 1 | Forces the second rank to the clear value while high |
| clear_to_mid | input | 1 | Clear target: 1 = midscale, 0 = zero |
| chain_out | output | 1 | Daisy-chain serial output |
| dac_code | output | LONG_W | Code delivered to the converter core |
| mid_cleared | output | 1 | High while the second rank holds midscale because of a clear |

## Verification
The case that is hardest to reach is a clear state that persists after clear has fallen while load is low, with the first rank rewritten in the meantime. The stimulus drops load first, pulses clear, performs a byte write, and only then raises load again, so that both the held clear value and the new first-rank word can be seen. A second case that is hard to reach is a strobe held high while the data pins keep changing; the bench keeps the strobe high for several clock cycles and changes the data in that window. Walking-one words cover every bit position for both word lengths and both shift orders.

// File: rtl/dwf_pkg.sv
package dwf_pkg;
    typedef enum logic [1:0] {
        RK_HOLD     = 2'd0,
        RK_TRACK    = 2'd1,
        RK_CLR_ZERO = 2'd2,
        RK_CLR_MID  = 2'd3
    } rank_state_t;

    // bit positions of the dual-use data pins in serial mode
    localparam int CTL_SIN       = 0;
    localparam int CTL_MSB_FIRST = 1;
    localparam int CTL_LONG      = 2;
endpackage

// File: rtl/dwf_sync.sv
module dwf_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dwf_first_rank.sv
module dwf_first_rank
    import dwf_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LONG_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              byte_mode,
    input  logic [BYTE_W-1:0] din,
    input  logic              hi_sel,
    input  logic              lo_sel,
    output logic [LONG_W-1:0] fr_code,
    output logic              chain_out
);
    localparam int SHORT_W = 2 * BYTE_W;
    localparam int PAD_W   = LONG_W - SHORT_W;

    logic [LONG_W-1:0] sr;
    logic              wide;
    logic              sin, msb_first, want_long;

    assign sin       = din[CTL_SIN];
    assign msb_first = din[CTL_MSB_FIRST];
    assign want_long = din[CTL_LONG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr   <= '0;
            wide <= 1'b0;
        end else if (strobe) begin
            if (byte_mode) begin
                wide <= 1'b0;
                sr[LONG_W-1:SHORT_W] <= '0;
                if (hi_sel) sr[SHORT_W-1:BYTE_W] <= din;
                if (lo_sel) sr[BYTE_W-1:0]       <= din;
            end else if (want_long) begin
                wide <= 1'b1;
                if (msb_first) sr <= {sr[LONG_W-2:0], sin};
                else           sr <= {sin, sr[LONG_W-1:1]};
            end else begin
                wide <= 1'b0;
                sr[LONG_W-1:SHORT_W] <= '0;
                if (msb_first) sr[SHORT_W-1:0] <= {sr[SHORT_W-2:0], sin};
                else           sr[SHORT_W-1:0] <= {sin, sr[SHORT_W-1:1]};
            end
        end
    end

    assign fr_code   = wide ? sr : {sr[SHORT_W-1:0], {PAD_W{1'b0}}};
    assign chain_out = wide ? sr[LONG_W-1] : sr[SHORT_W-1];

    AST_HI_BYTE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && byte_mode && hi_sel && !lo_sel |=>
        sr[SHORT_W-1:BYTE_W] == $past(din) && sr[BYTE_W-1:0] == $past(sr[BYTE_W-1:0])); // R7
    AST_MSB_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && !byte_mode && msb_first |=> sr[0] == $past(sin)); // R2
    AST_LSB_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && !byte_mode && !msb_first && !want_long |=> sr[SHORT_W-1] == $past(sin)); // R3
    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(sr)); // R11
endmodule

// File: rtl/dwf_second_rank.sv
module dwf_second_rank
    import dwf_pkg::*;
#(
    parameter int LONG_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clr,
    input  logic              clr_mid,
    input  logic [LONG_W-1:0] fr_code,
    output logic [LONG_W-1:0] dac_code,
    output logic              mid_flag
);
    localparam logic [LONG_W-1:0] MID_CODE = {1'b1, {(LONG_W-1){1'b0}}};

    rank_state_t st, nxt;

    always_comb begin
        nxt = st;
        if (clr) begin
            nxt = clr_mid ? RK_CLR_MID : RK_CLR_ZERO;
        end else if (load) begin
            nxt = RK_TRACK;
        end else begin
            unique case (st)
                RK_TRACK:    nxt = RK_HOLD;
                RK_HOLD:     nxt = RK_HOLD;
                RK_CLR_ZERO: nxt = RK_CLR_ZERO;
                RK_CLR_MID:  nxt = RK_CLR_MID;
                default:     nxt = RK_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RK_HOLD;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_code <= '0;
            mid_flag <= 1'b0;
        end else begin
            unique case (nxt)
                RK_TRACK:    dac_code <= fr_code;
                RK_CLR_ZERO: dac_code <= '0;
                RK_CLR_MID:  dac_code <= MID_CODE;
                default:     dac_code <= dac_code;
            endcase
            mid_flag <= (nxt == RK_CLR_MID);
        end
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !clr_mid |=> dac_code == '0 && !mid_flag); // R9
    AST_CLR_MID: assert property (@(posedge clk) disable iff (!rst_n)
        clr && clr_mid |=> dac_code == MID_CODE && mid_flag); // R9
    AST_TRACK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        !clr && load |=> dac_code == $past(fr_code) && !mid_flag); // R8
    AST_HOLD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr && !load |=> $stable(dac_code) && $stable(mid_flag)); // R10
endmodule

// File: rtl/dac_word_frontend.sv
module dac_word_frontend
    import dwf_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int LONG_W      = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_strobe,
    input  logic              byte_mode,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              hi_sel,
    input  logic              lo_sel,
    input  logic              load_en,
    input  logic              clear,
    input  logic              clear_to_mid,
    output logic              chain_out,
    output logic [LONG_W-1:0] dac_code,
    output logic              mid_cleared
);
    localparam int SYNC_W = BYTE_W + 7;

    logic [SYNC_W-1:0] raw, synced;
    logic              cs_s, bm_s, hi_s, lo_s, ld_s, clr_s, mid_s;
    logic [BYTE_W-1:0] din_s;
    logic              cs_q, strobe;
    logic [LONG_W-1:0] fr_code;

    assign raw = {cs_strobe, byte_mode, hi_sel, lo_sel, load_en, clear, clear_to_mid, data_in};

    dwf_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
    );

    assign {cs_s, bm_s, hi_s, lo_s, ld_s, clr_s, mid_s, din_s} = synced;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= 1'b0;
        else        cs_q <= cs_s;
    end

    assign strobe = cs_s & ~cs_q;

    dwf_first_rank #(.BYTE_W(BYTE_W), .LONG_W(LONG_W)) u_first (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .byte_mode(bm_s),
        .din(din_s), .hi_sel(hi_s), .lo_sel(lo_s),
        .fr_code(fr_code), .chain_out(chain_out)
    );

    dwf_second_rank #(.LONG_W(LONG_W)) u_second (
        .clk(clk), .rst_n(rst_n), .load(ld_s), .clr(clr_s), .clr_mid(mid_s),
        .fr_code(fr_code), .dac_code(dac_code), .mid_flag(mid_cleared)
    );

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe); // R11
endmodule

// File: tb/sim_dac_word_frontend.sv
`timescale 1ns/1ps
module sim_dac_word_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, bm = 1'b0, hs = 1'b0, ls = 1'b0;
    logic        ld = 1'b0, clr = 1'b0, cmid = 1'b0;
    logic [7:0]  din = '0;
    logic        chain;
    logic [17:0] code;
    logic        midf;
    int          checks = 0;
    int          fails = 0;

    always #10 clk = ~clk;

    dac_word_frontend u0 (
        .clk(clk), .rst_n(rst_n), .cs_strobe(cs), .byte_mode(bm), .data_in(din),
        .hi_sel(hs), .lo_sel(ls), .load_en(ld), .clear(clr), .clear_to_mid(cmid),
        .chain_out(chain), .dac_code(code), .mid_cleared(midf)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_cs();
        wait_n(3);
        cs = 1'b1;
        wait_n(4);
        cs = 1'b0;
        wait_n(3);
    endtask

    task automatic ser_bit(input logic b, input logic longw, input logic msbf);
        bm  = 1'b0;
        din = {5'b0, longw, msbf, b};
        pulse_cs();
    endtask

    task automatic send_word(input logic [17:0] w, input int len, input logic msbf);
        for (int i = 0; i < len; i++) begin
            ser_bit(msbf ? w[len-1-i] : w[i], len == 18, msbf);
        end
        wait_n(3);
    endtask

    task automatic byte_wr(input logic h, input logic l, input logic [7:0] v);
        bm = 1'b1; din = v; hs = h; ls = l;
        pulse_cs();
        hs = 1'b0; ls = 1'b0;
        wait_n(3);
    endtask

    function automatic logic [17:0] exp16(input logic [17:0] w);
        return {w[15:0], 2'b00};
    endfunction

    initial begin
        logic [17:0] w;
        logic [17:0] keep;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        chk("R1 reset code", code, 18'h0);
        chk("R1 reset chain", {17'b0, chain}, 18'h0);
        chk("R1 reset flag", {17'b0, midf}, 18'h0);

        ld = 1'b1;
        // R7 byte sweep, high byte first then low first
        for (int v = 0; v < 256; v += 17) begin
            byte_wr(1'b1, 1'b0, v[7:0]);
            byte_wr(1'b0, 1'b1, ~v[7:0]);
            chk("R7 hi then lo", code, {v[7:0], ~v[7:0], 2'b00});
            byte_wr(1'b0, 1'b1, v[7:0] ^ 8'h3C);
            byte_wr(1'b1, 1'b0, v[7:0] ^ 8'hC3);
            chk("R7 lo then hi", code, {v[7:0] ^ 8'hC3, v[7:0] ^ 8'h3C, 2'b00});
        end
        byte_wr(1'b1, 1'b1, 8'h00);
        byte_wr(1'b0, 1'b1, 8'h66);
        byte_wr(1'b1, 1'b0, 8'h5A);
        chk("R7 high only keeps low", code, {8'h5A, 8'h66, 2'b00});

        // R2 R3 R4 R6 walking ones for each length and order
        for (int len = 16; len <= 18; len += 2) begin
            for (int o = 0; o < 2; o++) begin
                for (int k = 0; k < len; k++) begin
                    w = 18'h1 << k;
                    send_word(w, len, o[0]);
                    if (len == 18)
                        chk(o[0] ? "R4 long msb-first" : "R4 long lsb-first", code, w);
                    else if (o[0])
                        chk("R2 short msb-first", code, exp16(w));
                    else
                        chk("R3 short lsb-first", code, exp16(w));
                    chk("R6 chain top bit", {17'b0, chain}, {17'b0, w[len-1]});
                end
            end
        end
        send_word(18'h0A5C3, 16, 1'b1);
        chk("R2 dense msb", code, exp16(18'h0A5C3));
        send_word(18'h2C3A5, 18, 1'b0);
        chk("R4 dense lsb", code, 18'h2C3A5);

        // R5 byte enables held high in serial mode
        hs = 1'b1; ls = 1'b1;
        send_word(18'h01234, 16, 1'b1);
        chk("R5 enables ignored msb", code, exp16(18'h01234));
        send_word(18'h0FEDC, 16, 1'b0);
        chk("R5 enables ignored lsb", code, exp16(18'h0FEDC));
        hs = 1'b0; ls = 1'b0;

        // R6 daisy chain shifting
        w = 18'h04B2D;
        send_word(w, 16, 1'b1);
        chk("R6 chain before", {17'b0, chain}, {17'b0, w[15]});
        ser_bit(1'b1, 1'b0, 1'b1);
        wait_n(3);
        chk("R6 chain after one", {17'b0, chain}, {17'b0, w[14]});
        chk("R6 shifted code", code, {w[14:0], 1'b1, 2'b00});
        ser_bit(1'b0, 1'b0, 1'b1);
        wait_n(3);
        chk("R6 chain after two", {17'b0, chain}, {17'b0, w[13]});

        // R11 edge-only writes
        byte_wr(1'b1, 1'b1, 8'h11);
        bm = 1'b1; hs = 1'b1; din = 8'h33;
        wait_n(3);
        cs = 1'b1;
        wait_n(4);
        din = 8'h77;
        wait_n(8);
        chk("R11 level high no write", code, {8'h33, 8'h11, 2'b00});
        cs = 1'b0;
        wait_n(8);
        chk("R11 falling edge no write", code, {8'h33, 8'h11, 2'b00});
        hs = 1'b0;

        // R8 hold while load low, transparency when high
        ld = 1'b0;
        wait_n(4);
        byte_wr(1'b1, 1'b0, 8'h99);
        chk("R8 hold with load low", code, {8'h33, 8'h11, 2'b00});
        ld = 1'b1;
        wait_n(5);
        chk("R8 follows on load", code, {8'h99, 8'h11, 2'b00});
        byte_wr(1'b0, 1'b1, 8'hE7);
        chk("R8 transparent update", code, {8'h99, 8'hE7, 2'b00});
        keep = {8'h99, 8'hE7, 2'b00};

        // R9 clear targets, priority over load
        clr = 1'b1; cmid = 1'b0;
        wait_n(5);
        chk("R9 clear zero", code, 18'h0);
        chk("R9 zero flag", {17'b0, midf}, 18'h0);
        cmid = 1'b1;
        wait_n(5);
        chk("R9 clear mid", code, 18'h20000);
        chk("R9 mid flag", {17'b0, midf}, 18'h1);
        clr = 1'b0;
        wait_n(5);
        chk("R10 restore after clear", code, keep);
        chk("R10 flag drops", {17'b0, midf}, 18'h0);

        // R10 clear value persists with load low; first rank rewritten meanwhile
        ld = 1'b0;
        wait_n(4);
        clr = 1'b1; cmid = 1'b1;
        wait_n(5);
        clr = 1'b0;
        wait_n(5);
        chk("R10 mid persists", code, 18'h20000);
        byte_wr(1'b1, 1'b0, 8'h42);
        chk("R10 mid persists after write", code, 18'h20000);
        chk("R10 flag persists", {17'b0, midf}, 18'h1);
        ld = 1'b1;
        wait_n(5);
        chk("R10 first rank intact", code, {8'h42, 8'hE7, 2'b00});
        chk("R10 flag cleared", {17'b0, midf}, 18'h0);
        ld = 1'b0;
        cmid = 1'b0; clr = 1'b1;
        wait_n(5);
        clr = 1'b0;
        wait_n(5);
        chk("R9 zero persists", code, 18'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule